// File: doc/BRIEF.md
# Segmented Tree Mismatch-Shaping Encoder

This block turns one sample of a nine-level flash decision (0 to 8) into on/off commands for ten single-bit DAC elements. Eight of the elements have a full step and two have a half step. A one-bit gain-calibration input adds half a step to the sample. The combined value, counted in half steps, enters a segment switch. The switch hands a share of zero, one or two half steps to the half-step pair and gives the rest, in full steps, to the unit segment. A three-level binary tree then divides the unit share among the eight unit elements. One more switching block splits the half-step share between the two half elements.

Every switching block divides its value v into (v+s)/2 and (v−s)/2. The sign s is zero when v is even and a pseudo-random +1 or −1 when v is odd. All nine signs of a sample (the segment sign and eight block signs) are registered next to the element enables, so that a downstream noise canceller can correlate against them. The sign bits come from one LFSR that advances once for each accepted sample. Because the signs are ready before the data arrives, the data path is only the adder tree in front of the output register.

Top module: `dem_tree_encoder`

## Requirements
- R1: While reset is asserted, `out_valid`, `unit_en`, `half_en`, `sgn_seg` and `sgn_blk` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `smp_valid` was sampled high. All outputs of that sample appear in that same cycle.
- R3: For every sample, 2·popcount(`unit_en`) + popcount(`half_en`) equals 2·code + `gec_bit`, where code is the effective code.
- R4: A `code` input above 8 is encoded exactly as code 8.
- R5: Each 2-bit sign field uses the codes 00 = 0, 01 = +1 and 11 = −1. The code 10 never appears.
- R6: Each switching block sends (v+s)/2 to its lower-indexed child and (v−s)/2 to its higher-indexed child, with s = 0 for even v and s = ±1 for odd v. The block order in `sgn_blk` is: field 0 is the root, which takes the unit share. Fields 1 and 2 are the middle pair: field 1 feeds units 0–3 and field 2 feeds units 4–7. Fields 3 to 6 are the leaf blocks for unit pairs (0,1), (2,3), (4,5) and (6,7). Field 7 splits the half-step share into `half_en[0]` and `half_en[1]`. Field i occupies bits [2i+1:2i].
- R7: With w = 2·code + `gec_bit`, the segment behaves as follows. If w is odd, the segment sign is 0 and the half share is 1. If w is 0, the sign is +1 and the half share is 0. For any other even w, the sign is ±1 and the half share is 1 − sign. The unit share is (w − half share)/2.
- R8: No split is ever illegal. The unit share lies in 0..8, the half share in 0..2, and every block output lies between 0 and its subtree's element count.
- R9: The signs are not fixed. Over many samples that give the segment an even nonzero w, both +1 and −1 occur, and the same holds for the root block on odd unit shares.
- R10: While `smp_valid` is low, all enable and sign outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample is present on `code` and `gec_bit` |
| code | input | 4 | Flash decision, 0..8; larger values saturate to 8 |
| gec_bit | input | 1 | Adds a half step to the sample |
| out_valid | output | 1 | The registered outputs hold a new sample |
| unit_en | output | 8 | Enables for the full-step elements |
| half_en | output | 2 | Enables for the half-step elements |
| sgn_seg | output | 2 | Segment switch sign, encoded as in R5 |
| sgn_blk | output | 16 | Eight block signs, field order as in R6 |

## Verification
The bench builds the encoder with the default 16-bit LFSR width and taps but a non-default seed. A different sign history exercises the claim that correctness does not depend on which random bits are drawn. For each output sample, the bench rebuilds the whole split tree from the input and the exported signs. This checks every block's parity rule and child values, and it covers the zero-value clamp and the saturated codes 9 to 15. A few hundred samples with this seed are enough to reach both polarities at the segment and at the root, so the randomness requirement is checked on real draws.

// File: rtl/dem_pkg.sv
package dem_pkg;

    localparam int CODE_W    = 4;
    localparam int FULL_CODE = 8;
    localparam int N_UNIT    = 8;
    localparam int N_HALF    = 2;
    localparam int N_BLK     = 8;
    localparam int N_RND     = N_BLK + 1;
    localparam int SGN_W     = 2;

    typedef enum logic [SGN_W-1:0] {
        SG_ZERO = 2'b00,
        SG_POS  = 2'b01,
        SG_NEG  = 2'b11
    } sgn_e;

endpackage

// File: rtl/dem_prng.sv
module dem_prng #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'h1D0F,
    parameter int              NOUT = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [NOUT-1:0] rnd
);

    localparam logic [W-1:0] SEED_NZ = (SEED == '0) ? W'(1) : SEED;

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED_NZ;
        end else if (step) begin
            state_q <= state_d;
        end
    end

    // each sign bit combines two distinct state bits
    for (genvar i = 0; i < NOUT; i++) begin : g_tap
        localparam int IA = i % W;
        localparam int IB = (i * 5 + 3) % W;
        assign rnd[i] = state_q[IA] ^ state_q[IB];
    end

endmodule

// File: rtl/dem_split.sv
module dem_split
    import dem_pkg::*;
#(
    parameter int VW = 4
) (
    input  logic [VW-1:0] v,
    input  logic          rnd,
    output logic [VW-2:0] lo,
    output logic [VW-2:0] hi,
    output sgn_e          sgn
);

    logic          odd;
    logic [VW-2:0] base;

    assign odd  = v[0];
    assign base = v[VW-1:1];

    // rnd = 1 selects -1; the odd remainder goes to the higher child
    assign lo = base + (VW-1)'(odd & ~rnd);
    assign hi = base + (VW-1)'(odd & rnd);

    always_comb begin
        unique case ({odd, rnd})
            2'b10:   sgn = SG_POS;
            2'b11:   sgn = SG_NEG;
            default: sgn = SG_ZERO;
        endcase
    end

endmodule

// File: rtl/dem_segment.sv
module dem_segment
    import dem_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              gec,
    input  logic              rnd,
    output logic [CODE_W-1:0] msb,
    output logic [1:0]        lsb,
    output sgn_e              sgn
);

    logic [CODE_W:0] w;
    logic [CODE_W:0] rest;

    assign w = {code, 1'b0} + (CODE_W+1)'(gec);

    always_comb begin
        if (w[0]) begin
            sgn = SG_ZERO;
            lsb = 2'd1;
        end else if (w == '0) begin
            sgn = SG_POS;
            lsb = 2'd0;
        end else if (rnd) begin
            sgn = SG_NEG;
            lsb = 2'd2;
        end else begin
            sgn = SG_POS;
            lsb = 2'd0;
        end
        rest = w - (CODE_W+1)'(lsb);
        msb  = rest[CODE_W:1];
    end

endmodule

// File: rtl/dem_tree_encoder.sv
module dem_tree_encoder
    import dem_pkg::*;
#(
    parameter int                 LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'h1D0F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [CODE_W-1:0]       code,
    input  logic                    gec_bit,
    output logic                    out_valid,
    output logic [N_UNIT-1:0]       unit_en,
    output logic [N_HALF-1:0]       half_en,
    output logic [SGN_W-1:0]        sgn_seg,
    output logic [N_BLK*SGN_W-1:0]  sgn_blk
);

    localparam int N_MID  = 2;
    localparam int N_LEAF = 4;

    logic [N_RND-1:0]        rnd;
    logic [CODE_W-1:0]       code_c;
    logic [CODE_W-1:0]       msb_v;
    logic [1:0]              lsb_v;
    sgn_e                    seg_s;
    logic [2:0]              mid_v  [N_MID];
    logic [1:0]              leaf_v [N_LEAF];
    sgn_e                    blk_s  [N_BLK];
    logic [N_UNIT-1:0]       unit_c;
    logic [N_HALF-1:0]       half_c;
    logic [N_BLK*SGN_W-1:0]  sgn_c;

    // signs are ready before the sample arrives
    dem_prng #(
        .W   (LFSR_W),
        .TAPS(LFSR_TAPS),
        .SEED(LFSR_SEED),
        .NOUT(N_RND)
    ) u_prng (
        .clk  (clk),
        .rst_n(rst_n),
        .step (smp_valid),
        .rnd  (rnd)
    );

    assign code_c = (code > CODE_W'(FULL_CODE)) ? CODE_W'(FULL_CODE) : code;

    dem_segment u_seg (
        .code(code_c),
        .gec (gec_bit),
        .rnd (rnd[N_BLK]),
        .msb (msb_v),
        .lsb (lsb_v),
        .sgn (seg_s)
    );

    dem_split #(.VW(4)) u_root (
        .v  (msb_v),
        .rnd(rnd[0]),
        .lo (mid_v[0]),
        .hi (mid_v[1]),
        .sgn(blk_s[0])
    );

    for (genvar m = 0; m < N_MID; m++) begin : g_mid
        dem_split #(.VW(3)) u_mid (
            .v  (mid_v[m]),
            .rnd(rnd[1+m]),
            .lo (leaf_v[2*m]),
            .hi (leaf_v[2*m+1]),
            .sgn(blk_s[1+m])
        );
    end

    for (genvar k = 0; k < N_LEAF; k++) begin : g_leaf
        dem_split #(.VW(2)) u_leaf (
            .v  (leaf_v[k]),
            .rnd(rnd[1+N_MID+k]),
            .lo (unit_c[2*k]),
            .hi (unit_c[2*k+1]),
            .sgn(blk_s[1+N_MID+k])
        );
    end

    dem_split #(.VW(2)) u_half (
        .v  (lsb_v),
        .rnd(rnd[N_BLK-1]),
        .lo (half_c[0]),
        .hi (half_c[1]),
        .sgn(blk_s[N_BLK-1])
    );

    always_comb begin
        for (int i = 0; i < N_BLK; i++) begin
            sgn_c[SGN_W*i +: SGN_W] = blk_s[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            unit_en   <= '0;
            half_en   <= '0;
            sgn_seg   <= '0;
            sgn_blk   <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                unit_en <= unit_c;
                half_en <= half_c;
                sgn_seg <= seg_s;
                sgn_blk <= sgn_c;
            end
        end
    end

endmodule

// File: rtl/dem_tree_encoder_chk.sv
module dem_tree_encoder_chk
    import dem_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic [CODE_W-1:0]       code,
    input logic                    gec_bit,
    input logic                    out_valid,
    input logic [N_UNIT-1:0]       unit_en,
    input logic [N_HALF-1:0]       half_en,
    input logic [SGN_W-1:0]        sgn_seg,
    input logic [N_BLK*SGN_W-1:0]  sgn_blk
);

    logic bad_sign;

    always_comb begin
        bad_sign = (sgn_seg == 2'b10);
        for (int i = 0; i < N_BLK; i++) begin
            if (sgn_blk[SGN_W*i +: SGN_W] == 2'b10) begin
                bad_sign = 1'b1;
            end
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_valid));

    // R3
    weighted_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($countones(unit_en) * 2 + $countones(half_en)) ==
            ((($past(code) > 4'd8) ? 16 : 2 * int'($past(code))) + int'($past(gec_bit)))));

    // R5
    sign_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !bad_sign);

    // R7
    seg_odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(gec_bit)) |-> (sgn_seg == 2'b00));

    // R7
    seg_even_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(gec_bit)) |-> (sgn_seg != 2'b00));

    for (genvar k = 0; k < 4; k++) begin : g_pair
        // R6
        leaf_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && sgn_blk[SGN_W*(3+k) +: SGN_W] == 2'b00)
                |-> (unit_en[2*k] == unit_en[2*k+1]));
        // R6
        leaf_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && sgn_blk[SGN_W*(3+k) +: SGN_W] == 2'b01)
                |-> (unit_en[2*k] && !unit_en[2*k+1]));
    end

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(unit_en) && $stable(half_en) &&
                        $stable(sgn_seg) && $stable(sgn_blk)));

endmodule

bind dem_tree_encoder dem_tree_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .code     (code),
    .gec_bit  (gec_bit),
    .out_valid(out_valid),
    .unit_en  (unit_en),
    .half_en  (half_en),
    .sgn_seg  (sgn_seg),
    .sgn_blk  (sgn_blk)
);

// File: tb/tb_dem_tree_encoder.sv
module tb_dem_tree_encoder;

    typedef struct {
        int c;
        int g;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [3:0]  code = '0;
    logic        gec_bit = 1'b0;
    logic        out_valid;
    logic [7:0]  unit_en;
    logic [1:0]  half_en;
    logic [1:0]  sgn_seg;
    logic [15:0] sgn_blk;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    int    seg_pos = 0, seg_neg = 0, root_pos = 0, root_neg = 0;

    always #10 clk = ~clk;

    dem_tree_encoder #(.LFSR_SEED(16'hACE1)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .code     (code),
        .gec_bit  (gec_bit),
        .out_valid(out_valid),
        .unit_en  (unit_en),
        .half_en  (half_en),
        .sgn_seg  (sgn_seg),
        .sgn_blk  (sgn_blk)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dec(input logic [1:0] f);
        case (f)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b11:   return -1;
            default: return 7;
        endcase
    endfunction

    function automatic int parity_ok(input int v, input int s);
        if (v % 2 == 0) return (s == 0) ? 1 : 0;
        return (s == 1 || s == -1) ? 1 : 0;
    endfunction

    task automatic check_item(input item_t it);
        int c, w, ss, hl, m, nbad;
        int sb[8];
        int val[8];
        int mid[2];
        int leaf[4];
        int ue[8];
        int he[2];
        c = (it.c > 8) ? 8 : it.c;
        w = 2 * c + it.g;
        ss = dec(sgn_seg);
        nbad = (ss == 7) ? 1 : 0;
        for (int i = 0; i < 8; i++) begin
            sb[i] = dec(sgn_blk[2*i +: 2]);
            if (sb[i] == 7) nbad++;
        end
        chk("R5 illegal sign codes", nbad, 0);
        // R7 segment rule
        if (w % 2 == 1) begin
            chk("R7 odd segment sign", ss, 0);
            hl = 1;
        end else if (w == 0) begin
            chk("R7 zero segment sign", ss, 1);
            hl = 0;
        end else begin
            chk("R7 even segment sign live", (ss == 1 || ss == -1) ? 1 : 0, 1);
            hl = 1 - ss;
            if (ss == 1) seg_pos++;
            if (ss == -1) seg_neg++;
        end
        m = (w - hl) / 2;
        chk("R8 unit share in range", (m >= 0 && m <= 8 && hl >= 0 && hl <= 2) ? 1 : 0, 1);
        // R6 tree rebuild
        val[0] = m;
        chk("R6 root parity", parity_ok(m, sb[0]), 1);
        if (m % 2 == 1 && sb[0] == 1) root_pos++;
        if (m % 2 == 1 && sb[0] == -1) root_neg++;
        mid[0] = (m + sb[0]) / 2;
        mid[1] = (m - sb[0]) / 2;
        for (int j = 0; j < 2; j++) begin
            chk("R6 middle parity", parity_ok(mid[j], sb[1+j]), 1);
            leaf[2*j]   = (mid[j] + sb[1+j]) / 2;
            leaf[2*j+1] = (mid[j] - sb[1+j]) / 2;
        end
        for (int k = 0; k < 4; k++) begin
            chk("R6 leaf parity", parity_ok(leaf[k], sb[3+k]), 1);
            ue[2*k]   = (leaf[k] + sb[3+k]) / 2;
            ue[2*k+1] = (leaf[k] - sb[3+k]) / 2;
        end
        chk("R6 half parity", parity_ok(hl, sb[7]), 1);
        he[0] = (hl + sb[7]) / 2;
        he[1] = (hl - sb[7]) / 2;
        for (int k = 0; k < 8; k++) begin
            if (it.c > 8) chk("R4 saturated unit enable", int'(unit_en[k]), ue[k]);
            else          chk("R6 unit enable", int'(unit_en[k]), ue[k]);
        end
        for (int k = 0; k < 2; k++) chk("R6 half enable", int'(half_en[k]), he[k]);
        chk("R3 weighted sum", 2 * $countones(unit_en) + $countones(half_en), w);
    endtask

    // monitor: pops one expected item per produced sample
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                chk("R2 output without sample", 1, 0);
            end else begin
                check_item(sb_q.pop_front());
            end
        end
    end

    task automatic send(input int c, input int g);
        @(negedge clk);
        smp_valid = 1'b1;
        code      = 4'(c);
        gec_bit   = 1'(g);
        sb_q.push_back('{c: c, g: g});
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            smp_valid = 1'b0;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0]  snap_u;
        logic [1:0]  snap_h;
        logic [15:0] snap_b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 unit_en in reset", int'(unit_en), 0);
        chk("R1 half_en in reset", int'(half_en), 0);
        chk("R1 signs in reset", int'(sgn_blk) + int'(sgn_seg), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R2 no output before input", int'(out_valid), 0);
        // sweep of all codes with and without the half step (R4 above 8)
        for (int c = 0; c < 16; c++) begin
            for (int g = 0; g < 2; g++) send(c, g);
        end
        idle(3);
        // R10 hold while idle
        for (int r = 0; r < 6; r++) begin
            send(r + 3, r % 2);
            idle(2);
            snap_u = unit_en;
            snap_h = half_en;
            snap_b = sgn_blk;
            idle(3);
            chk("R10 unit_en held", int'(unit_en), int'(snap_u));
            chk("R10 half_en held", int'(half_en), int'(snap_h));
            chk("R10 signs held", int'(sgn_blk), int'(snap_b));
        end
        // mixed traffic with gaps
        for (int n = 0; n < 300; n++) begin
            send(int'($urandom_range(0, 15)), int'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        // repeated even segment input for polarity coverage
        for (int n = 0; n < 40; n++) send(5, 0);
        for (int n = 0; n < 40; n++) send(7, 1);
        idle(4);
        chk("R2 every sample produced output", sb_q.size(), 0);
        // R9 both polarities observed
        chk("R9 segment +1 seen", (seg_pos > 0) ? 1 : 0, 1);
        chk("R9 segment -1 seen", (seg_neg > 0) ? 1 : 0, 1);
        chk("R9 root +1 seen", (root_pos > 0) ? 1 : 0, 1);
        chk("R9 root -1 seen", (root_neg > 0) ? 1 : 0, 1);
        finish_run();
    end

endmodule